// File: doc/BRIEF.md
# Key-Locked Decision Tree Classifier

This block classifies one feature vector by walking a single binary decision tree, one node per clock. The feature vector is written into a small register file ahead of time. Each internal node compares one stored feature against a constant threshold, and the result steers the walk to one of two child nodes. When a node whose children are class labels is evaluated, that label is written to the output register, a one-cycle done pulse is raised, and the engine returns to the root to wait for the next request.

The branch decision at every node goes through a key gate before it selects the next node. A gate is an XOR with that node's key bit, an XNOR with that node's key bit, or a plain buffer. The trained children of every gated node are stored swapped. Under the correct key the gate inverts the raw comparison, which undoes the swap. Under any other key, some inputs follow the wrong branch. The tree is held as elaborated constants. The key is a static input port with one bit per node, selected by node number.

Top module: `keyed_tree_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done and label are all 0.
- R2: A start pulse is taken only while the engine is idle (busy low). A start pulse seen while busy has no effect on the label, the done timing, or the idle state reached afterwards.
- R3: One node is evaluated per clock. Done rises exactly P rising edges after the edge that samples start, where P is the number of nodes on the path taken (3 for paths through node 1, and 2 for the path through node 2 in the default tree).
- R4: A node's test is true when the unsigned stored feature is less than or equal to the threshold, so equality counts as true. A true gated result selects the first stored child, and a false one selects the second.
- R5: Gate types: XOR gives raw XOR key bit, and XNOR gives the inverse of that. A buffer node passes the raw test and ignores its key bit, so flipping key bit 2 (the buffer at node 2) leaves every label unchanged.
- R6: With the correct key 8'h09 (bit 0 for the XOR root, bit 1 for the XNOR node 1, bit 3 for XOR node 3, bit 4 for XNOR node 4), the label equals the trained tree: f0<=100 ? (f1<=50 ? (f3<=30 ? 1 : 2) : (f4<=128 ? 3 : 4)) : (f2<=200 ? 5 : 6).
- R7: A key with a single flipped bit at a gated node (bit 0 or bit 1) yields a label different from the trained one for at least one input vector.
- R8: Done is high for exactly one cycle per classification. The label holds its value between done pulses, and busy is low in the cycle done is high.
- R9: The key is read combinationally at each node evaluation. A key change after the root has been evaluated leaves the root's decision alone and alters only the nodes evaluated later.
- R10: Features are written through the write port (3-bit address, 8-bit data) and are used by every later classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one classification (taken only when idle) |
| key | input | N_NODES | Secret key, bit i drives the gate of node i |
| feat_we | input | 1 | Feature write enable |
| feat_addr | input | 3 | Feature write index |
| feat_data | input | 8 | Feature write value |
| busy | output | 1 | Traversal in progress |
| done | output | 1 | One-cycle pulse when the label is written |
| label | output | 4 | Class label of the last finished classification |

## Verification
The hardest condition to reach from the ports is a key change that lands between two node evaluations of one traversal. Reaching it takes cycle-exact control of when the key moves relative to the start edge. The bench drives start on a falling edge and counts falling edges afterwards. It swaps the key right after the root has been evaluated and before node 1 is evaluated. It then checks that changing the root's bit at that point has no effect, while changing node 1's bit redirects the walk. A start pulse is also injected mid-walk to show that it neither restarts nor queues a second traversal.

// File: rtl/ktree_pkg.sv
package ktree_pkg;
    localparam int KT_NODE_W  = 10;
    localparam int KT_DATA_W  = 8;
    localparam int KT_FIDX_W  = 3;
    localparam int KT_LABEL_W = 4;

    typedef enum logic [1:0] {
        GATE_BUF  = 2'd0,
        GATE_XOR  = 2'd1,
        GATE_XNOR = 2'd2
    } gate_e;

    typedef struct packed {
        gate_e                 gate;
        logic                  term;
        logic [KT_FIDX_W-1:0]  fidx;
        logic [KT_DATA_W-1:0]  thresh;
        logic [KT_NODE_W-1:0]  nxt_t;
        logic [KT_NODE_W-1:0]  nxt_f;
    } node_t;

    typedef struct packed {
        logic                  busy;
        logic [KT_NODE_W-1:0]  state;
        logic                  done;
        logic [KT_LABEL_W-1:0] label;
    } eng_t;

    function automatic node_t kt_mk(gate_e g, logic term, int f, int th, int t, int fl);
        node_t n;
        n.gate   = g;
        n.term   = term;
        n.fidx   = KT_FIDX_W'(f);
        n.thresh = KT_DATA_W'(th);
        n.nxt_t  = KT_NODE_W'(t);
        n.nxt_f  = KT_NODE_W'(fl);
        return n;
    endfunction

    // Default locked tree; gated nodes store their trained children swapped.
    function automatic node_t kt_default_node(int idx);
        case (idx)
            0:       return kt_mk(GATE_XOR,  1'b0, 0, 100, 2, 1);
            1:       return kt_mk(GATE_XNOR, 1'b0, 1, 50,  4, 3);
            2:       return kt_mk(GATE_BUF,  1'b1, 2, 200, 5, 6);
            3:       return kt_mk(GATE_XOR,  1'b1, 3, 30,  2, 1);
            4:       return kt_mk(GATE_XNOR, 1'b1, 4, 128, 4, 3);
            default: return kt_mk(GATE_BUF,  1'b1, 0, 0,   0, 0);
        endcase
    endfunction
endpackage

// File: rtl/ktree_feat_mem.sv
module ktree_feat_mem
    import ktree_pkg::*;
#(
    parameter int FIDX_W = KT_FIDX_W,
    parameter int DATA_W = KT_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FIDX_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FIDX_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << FIDX_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en && (wr_addr == FIDX_W'(g))) mem_d[g] = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ktree_node_rom.sv
module ktree_node_rom
    import ktree_pkg::*;
#(
    parameter int N_NODES = 8
) (
    input  logic [KT_NODE_W-1:0] idx,
    output node_t                entry
);
    localparam int IDX_W = (N_NODES > 1) ? $clog2(N_NODES) : 1;

    node_t tbl [N_NODES];

    for (genvar g = 0; g < N_NODES; g++) begin : g_node
        assign tbl[g] = kt_default_node(g);
    end

    always_comb begin
        if ({1'b0, idx} < (KT_NODE_W+1)'(N_NODES))
            entry = tbl[idx[IDX_W-1:0]];
        else
            entry = kt_mk(GATE_BUF, 1'b1, 0, 0, 0, 0);
    end
endmodule

// File: rtl/ktree_key_gate.sv
module ktree_key_gate
    import ktree_pkg::*;
(
    input  logic  raw,
    input  gate_e gate,
    input  logic  key_bit,
    output logic  keyed
);
    always_comb begin
        case (gate)
            GATE_XOR:  keyed = raw ^ key_bit;
            GATE_XNOR: keyed = ~(raw ^ key_bit);
            default:   keyed = raw;
        endcase
    end
endmodule

// File: rtl/keyed_tree_engine.sv
module keyed_tree_engine
    import ktree_pkg::*;
#(
    parameter int N_NODES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [N_NODES-1:0]    key,
    input  logic                  feat_we,
    input  logic [KT_FIDX_W-1:0]  feat_addr,
    input  logic [KT_DATA_W-1:0]  feat_data,
    output logic                  busy,
    output logic                  done,
    output logic [KT_LABEL_W-1:0] label
);
    localparam int IDX_W = (N_NODES > 1) ? $clog2(N_NODES) : 1;

    eng_t                 eng_d, eng_q;
    node_t                node;
    logic [KT_DATA_W-1:0] fval;
    logic                 raw_le, take_t, key_bit;

    ktree_node_rom #(.N_NODES(N_NODES)) u_rom (
        .idx   (eng_q.state),
        .entry (node)
    );

    ktree_feat_mem #(.FIDX_W(KT_FIDX_W), .DATA_W(KT_DATA_W)) u_feat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (feat_we),
        .wr_addr (feat_addr),
        .wr_data (feat_data),
        .rd_addr (node.fidx),
        .rd_data (fval)
    );

    always_comb begin
        if ({1'b0, eng_q.state} < (KT_NODE_W+1)'(N_NODES))
            key_bit = key[eng_q.state[IDX_W-1:0]];
        else
            key_bit = 1'b0;
    end

    assign raw_le = (fval <= node.thresh);

    ktree_key_gate u_gate (
        .raw     (raw_le),
        .gate    (node.gate),
        .key_bit (key_bit),
        .keyed   (take_t)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.busy) begin
            if (start) eng_d.busy = 1'b1;
        end else if (node.term) begin
            eng_d.label = take_t ? node.nxt_t[KT_LABEL_W-1:0] : node.nxt_f[KT_LABEL_W-1:0];
            eng_d.done  = 1'b1;
            eng_d.busy  = 1'b0;
            eng_d.state = '0;
        end else begin
            eng_d.state = take_t ? node.nxt_t : node.nxt_f;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy  = eng_q.busy;
    assign done  = eng_q.done;
    assign label = eng_q.label;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    label_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(label));
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && eng_q.state == '0));
    // R2
    idle_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> eng_q.state == '0);
    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && eng_q.state == '0));
    // R3
    walk_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !node.term) |=> (busy && !done));
endmodule

// File: tb/keyed_tree_engine_tb.sv
module keyed_tree_engine_tb;
    localparam logic [7:0] GOOD_KEY = 8'h09;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] key = GOOD_KEY;
    logic       feat_we = 1'b0;
    logic [2:0] feat_addr = '0;
    logic [7:0] feat_data = '0;
    logic       busy, done;
    logic [3:0] label;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] fv [5];

    always #4 clk = ~clk;

    keyed_tree_engine #(.N_NODES(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key),
        .feat_we(feat_we), .feat_addr(feat_addr), .feat_data(feat_data),
        .busy(busy), .done(done), .label(label)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_label(input logic [7:0] f [5]);
        if (f[0] <= 100) begin
            if (f[1] <= 50) return (f[3] <= 30) ? 1 : 2;
            else            return (f[4] <= 128) ? 3 : 4;
        end
        return (f[2] <= 200) ? 5 : 6;
    endfunction

    function automatic int ref_len(input logic [7:0] f [5]);
        return (f[0] <= 100) ? 3 : 2;
    endfunction

    task automatic load(input int a, input int b, input int c, input int d, input int e);
        fv[0] = 8'(a); fv[1] = 8'(b); fv[2] = 8'(c); fv[3] = 8'(d); fv[4] = 8'(e);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            feat_we = 1'b1; feat_addr = 3'(i); feat_data = fv[i];
        end
        @(negedge clk);
        feat_we = 1'b0;
    endtask

    // Runs one classification; optional key swap or extra start after the root is evaluated.
    task automatic classify(input logic [7:0] k, input logic swap, input logic [7:0] k2,
                            input logic extra_start, output int lab, output int lat);
        @(negedge clk);
        key = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0; lab = -1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            lat++;
            if (start) start = 1'b0;
            if (done) begin lab = int'(label); break; end
            if (lat == 1 && swap) key = k2;
            if (lat == 1 && extra_start) start = 1'b1;
        end
        start = 1'b0;
        if (lab < 0) chk(1'b0, "watchdog done", lat, 0);
        key = GOOD_KEY;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && label == 0, "R1 reset", int'({busy, done, label}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && label == 0, "R1 after reset", int'({busy, done, label}), 0);
    endtask

    task automatic t_correct_key();
        int lab, lat;
        int vecs [8][5] = '{'{100, 50, 0, 30, 0}, '{90, 50, 0, 31, 0},
                            '{100, 51, 0, 0, 128}, '{0, 255, 0, 0, 129},
                            '{101, 0, 200, 0, 0}, '{255, 0, 201, 0, 0},
                            '{0, 0, 0, 0, 0}, '{101, 0, 0, 0, 0}};
        for (int v = 0; v < 8; v++) begin
            load(vecs[v][0], vecs[v][1], vecs[v][2], vecs[v][3], vecs[v][4]);
            classify(GOOD_KEY, 1'b0, 8'h0, 1'b0, lab, lat);
            chk(lab == ref_label(fv), "R6/R4/R10 label", lab, ref_label(fv));
            chk(lat == ref_len(fv), "R3 latency", lat, ref_len(fv));
            @(negedge clk);
            chk(done == 0 && label == 4'(ref_label(fv)), "R8 pulse and hold", int'(done), 0);
        end
    endtask

    task automatic t_wrong_key();
        int lab, lat;
        load(50, 10, 0, 0, 0);
        classify(GOOD_KEY ^ 8'h01, 1'b0, 8'h0, 1'b0, lab, lat);
        chk(lab != ref_label(fv), "R7 root bit flipped", lab, ref_label(fv));
        classify(GOOD_KEY ^ 8'h02, 1'b0, 8'h0, 1'b0, lab, lat);
        chk(lab != ref_label(fv), "R7 node1 XNOR bit flipped", lab, ref_label(fv));
        chk(lab == 3, "R5 XNOR inverted path", lab, 3);
    endtask

    task automatic t_buffer();
        int lab, lat;
        load(150, 0, 180, 0, 0);
        classify(GOOD_KEY ^ 8'h04, 1'b0, 8'h0, 1'b0, lab, lat);
        chk(lab == 5, "R5 buffer ignores key bit", lab, 5);
        load(150, 0, 220, 0, 0);
        classify(GOOD_KEY ^ 8'h04, 1'b0, 8'h0, 1'b0, lab, lat);
        chk(lab == 6, "R5 buffer ignores key bit", lab, 6);
    endtask

    task automatic t_midwalk_key();
        int lab, lat;
        load(20, 30, 0, 10, 200);
        classify(GOOD_KEY, 1'b1, GOOD_KEY ^ 8'h01, 1'b0, lab, lat);
        chk(lab == 1, "R9 late root bit no effect", lab, 1);
        classify(GOOD_KEY, 1'b1, GOOD_KEY ^ 8'h02, 1'b0, lab, lat);
        chk(lab == 4, "R9 late node1 bit redirects", lab, 4);
    endtask

    task automatic t_start_busy();
        int lab, lat;
        load(60, 70, 0, 0, 100);
        classify(GOOD_KEY, 1'b0, 8'h0, 1'b1, lab, lat);
        chk(lab == 3, "R2 label with start while busy", lab, 3);
        chk(lat == 3, "R2 latency with start while busy", lat, 3);
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R2 no queued walk", int'({busy, done}), 0);
    endtask

    initial begin
        t_reset();
        t_correct_key();
        t_wrong_key();
        t_buffer();
        t_midwalk_key();
        t_start_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule